// File: doc/BRIEF.md
# Instruction Fetch Cache with Per-Word Valid Bits

This block sits between a processor's instruction fetch port and the external bus interface. It is a read-only, direct-mapped cache of 64 lines. Each line stores two 16-bit words (an upper word at address bit 1 = 0 and a lower word at address bit 1 = 1). Each word has its own valid flag, so a line can be partly filled. A fetch is either one word or one aligned long word. When the requested word, or both words for a long fetch, are present under a matching tag, the fetch is answered from the cache. Otherwise the fetch goes out on the bus, and the line is written in the same clock in which the bus data reaches the processor.

How a miss fills a line depends on the size of the fetch and on the port width that the bus reports with its acknowledge. A long fetch, or a word fetch from a 32-bit port, writes and validates both words. A word fetch from a 16-bit port writes only the addressed word. The sibling word keeps its valid flag when the tag already matched, because that fill completes the line. The sibling is invalidated when the tag is replaced. Fetches into a configurable on-chip fast-memory window never allocate, because that memory is already as fast as the cache. While the cache is disabled, every fetch goes to the bus and nothing is allocated. A single-cycle invalidate input empties the whole cache.

Top module: `ifetch_cache`

## Requirements
- R1: A fetch accepted at a rising edge (cpu_req high while idle) that hits is acknowledged (cpu_ack high) during the following clock with cached data, and bus_req stays low. A hit needs the cache enabled, an address outside the fast window, a tag match on address bits [31:8], and a set valid flag on the addressed word. A long fetch needs both flags set.
- R2: On a miss, bus_req rises in the second cycle after acceptance, carrying the fetch address on bus_addr and the size on bus_long. cpu_ack stays low until bus_ack, then rises in the same cycle as bus_ack with the bus data. Total latency is 2+n cycles, where n is the number of cycles bus_ack is held off.
- R3: A long-fetch miss with the cache enabled, outside the fast window, writes both words of the line at index bits [7:2] and marks both valid. Any later fetch of either word or of the long word hits.
- R4: A word-fetch miss acknowledged as a 16-bit port (bus_port32 = 0) writes only the word selected by address bit 1, taking it from bus_rdata[15:0]. If the stored tag differed, the other word of the line becomes invalid.
- R5: A 16-bit-port word fill whose tag matches the stored tag leaves the other word's valid flag unchanged.
- R6: A word-fetch miss acknowledged as a 32-bit port writes both words from the full bus_rdata and marks both valid.
- R7: Fetches whose address satisfies (addr & FAST_MASK) == FAST_BASE (default window 0x00F0_0000 to 0x00FF_FFFF) never hit and never allocate.
- R8: While cache_en is low, every fetch misses and no line is written. A line cached earlier is not used while disabled.
- R9: A one-cycle pulse on inval_all clears every valid flag, so the next fetch of any address misses.
- R10: After reset, cpu_ack and bus_req are low and every line is invalid.
- R11: Data placement: a long fetch returns the aligned long word with the upper word in bits [31:16]. A word fetch returns the word in cpu_rdata[15:0] with the upper half zero. A 32-bit port returns the aligned long word, and a 16-bit port returns the addressed word in bus_rdata[15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cache_en | input | 1 | Cache enable |
| inval_all | input | 1 | Clears every valid flag |
| cpu_req | input | 1 | Fetch request, held until cpu_ack |
| cpu_addr | input | ADDR_W | Fetch byte address (bit 1 selects the word) |
| cpu_long | input | 1 | 1 = long-word fetch (address bit 1 must be 0), 0 = word fetch |
| cpu_ack | output | 1 | Fetch complete, data valid |
| cpu_rdata | output | 32 | Fetched data |
| bus_req | output | 1 | External fetch request |
| bus_addr | output | ADDR_W | External fetch address |
| bus_long | output | 1 | External fetch size |
| bus_ack | input | 1 | External fetch complete |
| bus_port32 | input | 1 | Width of the responding port with bus_ack: 1 = 32-bit, 0 = 16-bit |
| bus_rdata | input | 32 | External fetch data |

## Verification
A hit is due one clock after the edge that accepts the request. A miss raises bus_req one clock later and answers in the same cycle as bus_ack, giving 2+n cycles. The effect of a fill or an invalidate shows up on the next fetch. The bench counts rising edges from acceptance and samples one time unit after each edge, comparing the cycle of cpu_ack with 1 for an expected hit and 2+n for an expected miss. It also checks whether bus_req appeared, which exposes the hit or miss state of the line at the ports. A bench-side model of tags and per-word flags, updated from the fill rules, decides which outcome is expected.

// File: rtl/icx_pkg.sv
`timescale 1ns/1ps
package icx_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned LONG_W = 2 * WORD_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_BUS  = 2'd2
  } icx_state_e;

  typedef struct packed {
    logic we;
    logic set_u;
    logic set_l;
    logic clr_u;
    logic clr_l;
  } icx_fill_t;
endpackage

// File: rtl/icx_rst_sync.sv
`timescale 1ns/1ps
module icx_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/icx_ctrl.sv
`timescale 1ns/1ps
module icx_ctrl
  import icx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       hit_i,
  input  logic       bus_ack_i,
  output icx_state_e state_o,
  output logic       accept_o
);
  icx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_LOOK;
      ST_LOOK: state_d = hit_i ? ST_IDLE : ST_BUS;
      ST_BUS:  if (bus_ack_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o  = state_q;
  assign accept_o = (state_q == ST_IDLE) && req_i;

  // R2
  look_leaves_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_LOOK) |=> (state_q != ST_LOOK));
endmodule

// File: rtl/icx_tag_store.sv
`timescale 1ns/1ps
module icx_tag_store
  import icx_pkg::*;
#(
  parameter int unsigned LINES = 64,
  parameter int unsigned TAG_W = 24,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             inval_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic             rd_vu_o,
  output logic             rd_vl_o,
  input  icx_fill_t        wr_cmd_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] vu_q, vu_d;
  logic [LINES-1:0] vl_q, vl_d;
  logic [LINES-1:0] line_we;

  for (genvar g = 0; g < LINES; g++) begin : g_line_we
    assign line_we[g] = wr_cmd_i.we && (wr_idx_i == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (line_we[i]) tag_q[i] <= wr_tag_i;
    end
  end

  always_comb begin
    vu_d = vu_q;
    vl_d = vl_q;
    if (inval_i) begin
      vu_d = '0;
      vl_d = '0;
    end else if (wr_cmd_i.we) begin
      if (wr_cmd_i.set_u)      vu_d[wr_idx_i] = 1'b1;
      else if (wr_cmd_i.clr_u) vu_d[wr_idx_i] = 1'b0;
      if (wr_cmd_i.set_l)      vl_d[wr_idx_i] = 1'b1;
      else if (wr_cmd_i.clr_l) vl_d[wr_idx_i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vu_q <= '0;
      vl_q <= '0;
    end else begin
      vu_q <= vu_d;
      vl_q <= vl_d;
    end
  end

  assign rd_tag_o = tag_q[rd_idx_i];
  assign rd_vu_o  = vu_q[rd_idx_i];
  assign rd_vl_o  = vl_q[rd_idx_i];

  // R9
  inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    inval_i |=> (vu_q == '0) && (vl_q == '0));

  // R3
  both_valid_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_cmd_i.we && wr_cmd_i.set_u && wr_cmd_i.set_l && !inval_i)
      |=> (vu_q[$past(wr_idx_i)] && vl_q[$past(wr_idx_i)]));

  // R4
  sibling_lo_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_cmd_i.we && wr_cmd_i.clr_l && !wr_cmd_i.set_l)
      |=> !vl_q[$past(wr_idx_i)]);

  // R4
  sibling_hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_cmd_i.we && wr_cmd_i.clr_u && !wr_cmd_i.set_u)
      |=> !vu_q[$past(wr_idx_i)]);
endmodule

// File: rtl/icx_data_store.sv
`timescale 1ns/1ps
module icx_data_store
  import icx_pkg::*;
#(
  parameter int unsigned LINES = 64,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              wr_u_i,
  input  logic              wr_l_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_du_i,
  input  logic [WORD_W-1:0] wr_dl_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_du_o,
  output logic [WORD_W-1:0] rd_dl_o
);
  logic [WORD_W-1:0] du_q [LINES];
  logic [WORD_W-1:0] dl_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_u_i) du_q[wr_idx_i] <= wr_du_i;
    if (wr_l_i) dl_q[wr_idx_i] <= wr_dl_i;
  end

  assign rd_du_o = du_q[rd_idx_i];
  assign rd_dl_o = dl_q[rd_idx_i];
endmodule

// File: rtl/icx_fill_ctl.sv
`timescale 1ns/1ps
module icx_fill_ctl
  import icx_pkg::*;
(
  input  logic              done_i,
  input  logic              en_i,
  input  logic              fast_i,
  input  logic              long_i,
  input  logic              a1_i,
  input  logic              port32_i,
  input  logic              tag_hit_i,
  input  logic [LONG_W-1:0] bus_data_i,
  output icx_fill_t         cmd_o,
  output logic [WORD_W-1:0] du_o,
  output logic [WORD_W-1:0] dl_o,
  output logic [LONG_W-1:0] cpu_data_o
);
  logic [WORD_W-1:0] bus_hi, bus_lo, word_sel;

  assign bus_hi = bus_data_i[LONG_W-1:WORD_W];
  assign bus_lo = bus_data_i[WORD_W-1:0];

  always_comb begin
    cmd_o    = '0;
    du_o     = bus_hi;
    dl_o     = bus_lo;
    cmd_o.we = done_i && en_i && !fast_i;
    if (long_i || port32_i) begin
      cmd_o.set_u = 1'b1;
      cmd_o.set_l = 1'b1;
    end else if (!a1_i) begin
      du_o        = bus_lo;
      cmd_o.set_u = 1'b1;
      cmd_o.clr_l = !tag_hit_i;
    end else begin
      cmd_o.set_l = 1'b1;
      cmd_o.clr_u = !tag_hit_i;
    end
  end

  always_comb begin
    if (port32_i) word_sel = a1_i ? bus_lo : bus_hi;
    else          word_sel = bus_lo;
    cpu_data_o = long_i ? bus_data_i : {{WORD_W{1'b0}}, word_sel};
  end
endmodule

// File: rtl/ifetch_cache.sv
`timescale 1ns/1ps
module ifetch_cache
  import icx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LINES     = 64,
  parameter logic [31:0] FAST_BASE = 32'h00F0_0000,
  parameter logic [31:0] FAST_MASK = 32'hFFF0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              inval_all,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_long,
  output logic              cpu_ack,
  output logic [31:0]       cpu_rdata,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_long,
  input  logic              bus_ack,
  input  logic              bus_port32,
  input  logic [31:0]       bus_rdata
);
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned IDX_L = 2;
  localparam int unsigned TAG_L = IDX_L + IDX_W;
  localparam int unsigned TAG_W = ADDR_W - TAG_L;

  logic              rst_s;
  icx_state_e        state;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic              long_q;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag, rd_tag;
  logic              a1, fast, tag_match, rd_vu, rd_vl, word_ok, hit;
  logic [WORD_W-1:0] rd_du, rd_dl, fill_du, fill_dl;
  logic [31:0]       bus_cpu_data, hit_data;
  icx_fill_t         fill_cmd;
  logic              bus_done;
  logic              unused_addr_lsb;

  icx_rst_sync u_rst (.clk(clk), .rst_ni(rst_n), .rst_no(rst_s));

  icx_ctrl u_ctrl (
    .clk(clk), .rst_ni(rst_s), .req_i(cpu_req), .hit_i(hit),
    .bus_ack_i(bus_ack), .state_o(state), .accept_o(accept)
  );

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= cpu_addr;
      long_q <= cpu_long;
    end
  end

  assign idx             = addr_q[TAG_L-1:IDX_L];
  assign tag             = addr_q[ADDR_W-1:TAG_L];
  assign a1              = addr_q[1];
  assign unused_addr_lsb = addr_q[0];
  assign fast            = ((32'(addr_q) & FAST_MASK) == FAST_BASE);

  icx_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_ni(rst_s), .inval_i(inval_all),
    .rd_idx_i(idx), .rd_tag_o(rd_tag), .rd_vu_o(rd_vu), .rd_vl_o(rd_vl),
    .wr_cmd_i(fill_cmd), .wr_idx_i(idx), .wr_tag_i(tag)
  );

  icx_data_store #(.LINES(LINES)) u_data (
    .clk(clk),
    .wr_u_i(fill_cmd.we && fill_cmd.set_u),
    .wr_l_i(fill_cmd.we && fill_cmd.set_l),
    .wr_idx_i(idx), .wr_du_i(fill_du), .wr_dl_i(fill_dl),
    .rd_idx_i(idx), .rd_du_o(rd_du), .rd_dl_o(rd_dl)
  );

  assign tag_match = (rd_tag == tag);
  assign word_ok   = long_q ? (rd_vu && rd_vl) : (a1 ? rd_vl : rd_vu);
  assign hit       = cache_en && !fast && tag_match && word_ok;
  assign bus_done  = (state == ST_BUS) && bus_ack;

  icx_fill_ctl u_fill (
    .done_i(bus_done), .en_i(cache_en), .fast_i(fast), .long_i(long_q),
    .a1_i(a1), .port32_i(bus_port32), .tag_hit_i(tag_match),
    .bus_data_i(bus_rdata), .cmd_o(fill_cmd), .du_o(fill_du),
    .dl_o(fill_dl), .cpu_data_o(bus_cpu_data)
  );

  assign hit_data  = long_q ? {rd_du, rd_dl} : {{WORD_W{1'b0}}, (a1 ? rd_dl : rd_du)};
  assign cpu_ack   = ((state == ST_LOOK) && hit) || bus_done;
  assign cpu_rdata = (state == ST_BUS) ? bus_cpu_data : hit_data;
  assign bus_req   = (state == ST_BUS);
  assign bus_addr  = addr_q;
  assign bus_long  = long_q;

  // R1
  hit_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ((state == ST_LOOK) && hit) |-> (cpu_ack && !bus_req));

  // R2
  miss_to_bus_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ((state == ST_LOOK) && !hit) |=> bus_req);

  // R2
  stall_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_req && !bus_ack) |-> !cpu_ack);

  // R2
  bus_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_req && $past(bus_req)) |-> $stable(bus_addr));

  // R7
  fast_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_s)
    fill_cmd.we |-> !fast);

  // R8
  off_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_s)
    fill_cmd.we |-> cache_en);
endmodule

// File: tb/ifetch_cache_bench.sv
`timescale 1ns/1ps
module ifetch_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FB = 32'h00F0_0000;
  localparam logic [31:0] FM = 32'hFFF0_0000;

  logic        clk = 1'b0;
  logic        rst_n, cache_en, inval_all, cpu_req, cpu_long, cpu_ack;
  logic [31:0] cpu_addr, cpu_rdata, bus_addr, bus_rdata;
  logic        bus_req, bus_long, bus_ack, bus_port32;

  int n_chk = 0;
  int n_fail = 0;

  logic [23:0] m_tag [64];
  bit          m_vu  [64];
  bit          m_vl  [64];
  bit          m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifetch_cache u_ifetch_cache (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .inval_all(inval_all),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_long(cpu_long),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_long(bus_long), .bus_ack(bus_ack),
    .bus_port32(bus_port32), .bus_rdata(bus_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_long(input logic [31:0] a);
    logic [31:0] b;
    b = {a[31:2], 2'b00};
    return (b * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [31:0] exp_data(input logic [31:0] a, input bit lng);
    logic [31:0] m;
    m = mem_long(a);
    if (lng) return m;
    return {16'h0000, (a[1] ? m[15:0] : m[31:16])};
  endfunction

  function automatic bit is_fast(input logic [31:0] a);
    return (a & FM) == FB;
  endfunction

  function automatic bit exp_hit(input logic [31:0] a, input bit lng);
    int i;
    i = int'(a[7:2]);
    if (!m_en || is_fast(a) || m_tag[i] != a[31:8]) return 1'b0;
    if (lng) return m_vu[i] && m_vl[i];
    return a[1] ? m_vl[i] : m_vu[i];
  endfunction

  task automatic m_fill(input logic [31:0] a, input bit lng, input bit p32);
    int i;
    bit tm;
    i = int'(a[7:2]);
    if (!m_en || is_fast(a)) return;
    tm = (m_tag[i] == a[31:8]);
    m_tag[i] = a[31:8];
    if (lng || p32) begin
      m_vu[i] = 1'b1; m_vl[i] = 1'b1;
    end else if (!a[1]) begin
      m_vu[i] = 1'b1; if (!tm) m_vl[i] = 1'b0;
    end else begin
      m_vl[i] = 1'b1; if (!tm) m_vu[i] = 1'b0;
    end
  endtask

  task automatic do_fetch(input logic [31:0] a, input bit lng, input bit p32,
                          input int waits, output logic [31:0] data,
                          output bit used, output int lat);
    bit got;
    int cyc;
    got = 1'b0; used = 1'b0; cyc = 0; data = '0;
    @(negedge clk);
    cpu_addr = a; cpu_long = lng; cpu_req = 1'b1;
    while (!got && cyc < 40) begin
      @(posedge clk); #1; cyc++;
      if (cpu_ack) begin
        got = 1'b1; data = cpu_rdata; cpu_req = 1'b0;
        @(posedge clk); #1;
      end else if (bus_req) begin
        used = 1'b1;
        chk(bus_addr == a && bus_long == lng, "R2", "bus address/size", bus_addr, a);
        for (int w = 0; w < waits; w++) begin
          @(posedge clk); #1; cyc++;
          chk(!cpu_ack, "R2", "ack before bus ack", 32'(cpu_ack), 32'd0);
        end
        bus_port32 = p32;
        if (lng || p32) bus_rdata = mem_long(a);
        else bus_rdata = {16'($urandom), exp_data(a, 1'b0)};
        bus_ack = 1'b1;
        #1;
        if (cpu_ack) begin got = 1'b1; data = cpu_rdata; end
        cpu_req = 1'b0;
        @(posedge clk); #1;
        bus_ack = 1'b0;
      end
    end
    cpu_req = 1'b0;
    lat = cyc;
    if (!got) chk(1'b0, "R2", "fetch never acknowledged", 32'd0, 32'd1);
  endtask

  task automatic run_one(input logic [31:0] a, input bit lng, input bit p32,
                         input int waits, input string req);
    logic [31:0] d;
    bit used, eh;
    int lat;
    eh = exp_hit(a, lng);
    do_fetch(a, lng, p32, waits, d, used, lat);
    chk(d == exp_data(a, lng), "R11", {req, " data"}, d, exp_data(a, lng));
    chk(used == !eh, req, "hit/miss seen at bus_req", 32'(used), 32'(!eh));
    chk(lat == (eh ? 1 : 2 + waits), eh ? "R1" : "R2", "latency", 32'(lat),
        32'(eh ? 1 : 2 + waits));
    if (!eh) m_fill(a, lng, p32);
  endtask

  task automatic set_en(input bit e);
    @(negedge clk);
    cache_en = e; m_en = e;
  endtask

  task automatic pulse_inval();
    @(negedge clk);
    inval_all = 1'b1;
    @(negedge clk);
    inval_all = 1'b0;
    for (int i = 0; i < 64; i++) begin m_vu[i] = 1'b0; m_vl[i] = 1'b0; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "R2", "watchdog expired", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] a;
    bit lng;
    void'($urandom(32'd20611));
    for (int i = 0; i < 64; i++) begin m_tag[i] = '0; m_vu[i] = 1'b0; m_vl[i] = 1'b0; end
    rst_n = 1'b0; cache_en = 1'b1; m_en = 1'b1; inval_all = 1'b0;
    cpu_req = 1'b0; cpu_addr = '0; cpu_long = 1'b0;
    bus_ack = 1'b0; bus_port32 = 1'b0; bus_rdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(!cpu_ack && !bus_req, "R10", "outputs after reset",
        {30'd0, cpu_ack, bus_req}, 32'd0);

    // R10: first fetch after reset misses; R4 / R5 partial fills on a 16-bit port
    run_one(32'h0001_2340, 1'b0, 1'b0, 0, "R10");
    run_one(32'h0001_2340, 1'b0, 1'b0, 1, "R4");
    run_one(32'h0001_2342, 1'b0, 1'b0, 2, "R4");
    run_one(32'h0001_2340, 1'b1, 1'b0, 0, "R5");
    run_one(32'h0005_6742, 1'b0, 1'b0, 0, "R4");
    run_one(32'h0005_6740, 1'b0, 1'b0, 3, "R4");
    run_one(32'h0005_6740, 1'b1, 1'b0, 0, "R5");
    // R6: word fetch from a 32-bit port fills the whole line
    run_one(32'h0000_110A, 1'b0, 1'b1, 1, "R6");
    run_one(32'h0000_1108, 1'b0, 1'b0, 0, "R6");
    run_one(32'h0000_1108, 1'b1, 1'b0, 0, "R6");
    // R3: long fill
    run_one(32'h0000_2210, 1'b1, 1'b0, 2, "R3");
    run_one(32'h0000_2212, 1'b0, 1'b0, 0, "R3");
    run_one(32'h0000_2210, 1'b0, 1'b1, 0, "R3");
    // R7: fast window never allocates
    run_one(32'h00F0_0020, 1'b1, 1'b1, 0, "R7");
    run_one(32'h00F0_0020, 1'b1, 1'b1, 0, "R7");
    run_one(32'h00FF_FF22, 1'b0, 1'b1, 1, "R7");
    run_one(32'h00FF_FF22, 1'b0, 1'b1, 0, "R7");
    // R8: disabled cache
    set_en(1'b0);
    run_one(32'h0000_2210, 1'b1, 1'b0, 0, "R8");
    run_one(32'h0000_3330, 1'b1, 1'b1, 0, "R8");
    set_en(1'b1);
    run_one(32'h0000_3330, 1'b1, 1'b1, 0, "R8");
    run_one(32'h0000_2210, 1'b1, 1'b0, 0, "R8");
    // R9: invalidate all
    pulse_inval();
    run_one(32'h0000_2210, 1'b1, 1'b0, 0, "R9");
    run_one(32'h0000_1108, 1'b0, 1'b0, 0, "R9");
    run_one(32'h0000_3330, 1'b0, 1'b1, 0, "R9");

    for (int k = 0; k < 800; k++) begin
      logic [23:0] t;
      case ($urandom % 4)
        0: t = 24'h000010;
        1: t = 24'h000011;
        2: t = 24'h00F000;
        default: t = 24'h000123;
      endcase
      lng = ($urandom % 3) == 0;
      a = {t, 6'($urandom), (lng ? 1'b0 : 1'($urandom)), 1'b0};
      if (k % 97 == 50) pulse_inval();
      if (k % 50 == 30) set_en(1'b0);
      if (k % 50 == 36) set_en(1'b1);
      run_one(a, lng, 1'($urandom), int'($urandom % 4), "R1");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule